// File: doc/BRIEF.md
# Run-Length Raster Video Player

This block plays a compressed monochrome picture out to a raster panel that takes four signals: one video bit, a dot clock, a line sync and a frame sync. The picture is held in a byte-wide memory as a stream of code bytes. Each byte carries a pixel level in its top bit and a run length in its low seven bits. The player fetches one byte, emits the whole run, then fetches the next. It cuts every line off at a fixed pixel count and every frame off at a fixed line count, then idles for a programmable retrace period before it starts the next frame from the same base address.

After reset the player waits. A one-cycle `start` pulse begins playback, and frames then repeat without further action. A frame starts with a single-cycle low pulse on `vsync`. Each line starts with a single-cycle high pulse on `hsync`. Each pixel takes two cycles. In the first, `video` is set up with `dot_clk` low. In the second, `dot_clk` is high, so the panel latches on the rising edge. A code fetch costs two cycles: one for the read request and one for the returned byte. The memory returns data one cycle after `mem_rd`.

Top module: `rle_raster_player`

## Requirements
- R1: While reset is asserted, `vsync` is 1, and `hsync`, `dot_clk`, `video`, `mem_rd` and `frame_done` are 0.
- R2: A code byte holds the pixel level in bit 7 (1 = lit) and a run of bits[6:0]+1 pixels, from 1 to 128. For example, 0x80 is one lit pixel and 0x7F is 128 dark pixels.
- R3: A line ends as soon as PIX_PER_LINE pixels have been emitted. Any run count still left is discarded, and the next line starts by fetching a fresh byte.
- R4: Each line starts with `hsync` high for exactly one cycle and carries exactly PIX_PER_LINE dot clock pulses. `dot_clk` is never high while either sync is active.
- R5: After LINES_PER_FRAME lines, the block spends `retrace_len`+1 cycles with no sync, no dot clock and no read. The frame period in cycles is therefore 1 + L + 2·B + 2·P·L + `retrace_len` + 1, where P is the pixels per line, L is the lines per frame and B is the number of bytes fetched in the frame.
- R6: `vsync` goes low for exactly one cycle at the start of each frame.
- R7: The first read of every frame is at `base_addr`. Later reads step through consecutive addresses and wrap at the top of the address space.
- R8: `frame_done` pulses for one cycle on the last retrace cycle of each frame. The next cycle is the `vsync` pulse.
- R9: Before `start`, the block issues no read, no sync and no dot clock.
- R10: `dot_clk` is high for one cycle at a time, and `video` keeps the same value in the cycle before each rising edge of `dot_clk`.
- R11: One read is made per code byte, never while `dot_clk` is high. No more than 128 dot clocks follow any single read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins continuous playback |
| base_addr | input | ADDR_W | Address of the first code byte of every frame |
| retrace_len | input | RT_W | Retrace idle time, in cycles minus one |
| mem_rd | output | 1 | Read request to the code memory |
| mem_addr | output | ADDR_W | Read address |
| mem_data | input | 8 | Code byte, valid the cycle after `mem_rd` |
| video | output | 1 | Pixel level to the panel |
| dot_clk | output | 1 | Pixel clock, panel latches on the rising edge |
| hsync | output | 1 | Line start pulse, active high |
| vsync | output | 1 | Frame start pulse, active low |
| frame_done | output | 1 | One-cycle strobe at the end of each frame |

## Verification
The assertions take for granted that `base_addr` is held steady while a frame plays. They also assume the memory answers every read with a byte on the following cycle, so the first-address and per-read run checks compare against the live `base_addr` port. The bench changes `base_addr`, `retrace_len` and the memory contents only while reset is held, and then lets several whole frames play. Its patterns include a base address near the top of memory, so the read pointer wraps during a frame.

// File: rtl/rle_pkg.sv
package rle_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_VS, ST_HS, ST_REQ, ST_LOAD, ST_LO, ST_HI, ST_RT
   } scan_st_t;

   typedef struct packed {
      logic       level;
      logic [6:0] run_m1;
   } code_t;

   localparam int unsigned CODE_W = 8;
endpackage

// File: rtl/rle_byte_fetch.sv
module rle_byte_fetch #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              req,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr
);
   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (restart) ptr_q <= base_addr;
      else if (req)     ptr_q <= ptr_q + 1'b1;
   end

   assign mem_rd   = req;
   assign mem_addr = ptr_q;
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter
   import rle_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  code_t code,
   input  logic  step,
   output logic  level,
   output logic  run_last
);
   logic       level_q;
   logic [6:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         left_q  <= '0;
      end else if (load) begin
         level_q <= code.level;
         left_q  <= code.run_m1;
      end else if (step && left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign level    = level_q;
   assign run_last = (left_q == '0);
endmodule

// File: rtl/rle_retrace_timer.sv
module rle_retrace_timer #(
   parameter int unsigned RT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [RT_W-1:0] len,
   input  logic            active,
   output logic            expired
);
   logic [RT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (load)                     cnt_q <= len;
      else if (active && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/rle_raster_player.sv
module rle_raster_player
   import rle_pkg::*;
#(
   parameter int unsigned ADDR_W          = 16,
   parameter int unsigned RT_W            = 16,
   parameter int unsigned PIX_PER_LINE    = 256,
   parameter int unsigned LINES_PER_FRAME = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [RT_W-1:0]   retrace_len,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_data,
   output logic              video,
   output logic              dot_clk,
   output logic              hsync,
   output logic              vsync,
   output logic              frame_done
);
   localparam int unsigned DOT_W  = (PIX_PER_LINE    > 2) ? $clog2(PIX_PER_LINE)    : 1;
   localparam int unsigned LINE_W = (LINES_PER_FRAME > 2) ? $clog2(LINES_PER_FRAME) : 1;

   if (PIX_PER_LINE < 2) begin : g_bad_pix
      $error("PIX_PER_LINE must be at least 2");
   end
   if (LINES_PER_FRAME < 2) begin : g_bad_lines
      $error("LINES_PER_FRAME must be at least 2");
   end
   if (ADDR_W < 1 || RT_W < 1) begin : g_bad_width
      $error("ADDR_W and RT_W must be positive");
   end

   scan_st_t          st_q, st_d;
   logic [DOT_W-1:0]  dot_q;
   logic [LINE_W-1:0] line_q;
   logic              dot_last, line_last, run_last, level, rt_expired;

   assign dot_last  = (dot_q  == DOT_W'(PIX_PER_LINE - 1));
   assign line_last = (line_q == LINE_W'(LINES_PER_FRAME - 1));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_VS;
         ST_VS:   st_d = ST_HS;
         ST_HS:   st_d = ST_REQ;
         ST_REQ:  st_d = ST_LOAD;
         ST_LOAD: st_d = ST_LO;
         ST_LO:   st_d = ST_HI;
         ST_HI: begin
            if (dot_last)      st_d = line_last ? ST_RT : ST_HS;
            else if (run_last) st_d = ST_REQ;
            else               st_d = ST_LO;
         end
         ST_RT:   if (rt_expired) st_d = ST_VS;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         dot_q  <= '0;
         line_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_VS) line_q <= '0;
         if (st_q == ST_HS) dot_q  <= '0;
         if (st_q == ST_HI) begin
            dot_q <= dot_q + 1'b1;
            if (dot_last) line_q <= line_q + 1'b1;
         end
      end
   end

   rle_byte_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (st_q == ST_VS),
      .base_addr (base_addr),
      .req       (st_q == ST_REQ),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr)
   );

   rle_run_counter u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st_q == ST_LOAD),
      .code     (code_t'(mem_data)),
      .step     (st_q == ST_HI),
      .level    (level),
      .run_last (run_last)
   );

   rle_retrace_timer #(.RT_W(RT_W)) u_rt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (st_q == ST_HI && dot_last && line_last),
      .len     (retrace_len),
      .active  (st_q == ST_RT),
      .expired (rt_expired)
   );

   assign vsync      = (st_q != ST_VS);
   assign hsync      = (st_q == ST_HS);
   assign dot_clk    = (st_q == ST_HI);
   assign video      = (st_q == ST_LO || st_q == ST_HI) && level;
   assign frame_done = (st_q == ST_RT) && rt_expired;
endmodule

// File: rtl/rle_raster_checker.sv
module rle_raster_checker #(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned PIX_PER_LINE = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] base_addr,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              video,
   input logic              dot_clk,
   input logic              hsync,
   input logic              vsync,
   input logic              frame_done
);
   localparam int unsigned CW = $clog2(PIX_PER_LINE + 1) + 1;

   logic [CW-1:0] line_dots;
   logic          line_open;
   logic [8:0]    dots_since_rd;
   logic          await_first;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_dots     <= '0;
         line_open     <= 1'b0;
         dots_since_rd <= '0;
         await_first   <= 1'b0;
      end else begin
         if (hsync) begin
            line_dots <= '0;
            line_open <= 1'b1;
         end else if (dot_clk) begin
            line_dots <= line_dots + 1'b1;
         end
         if (frame_done) line_open <= 1'b0;
         if (mem_rd) dots_since_rd <= '0;
         else if (dot_clk && dots_since_rd != 9'h1FF) dots_since_rd <= dots_since_rd + 1'b1;
         if (!vsync) await_first <= 1'b1;
         else if (mem_rd) await_first <= 1'b0;
      end
   end

   AST_VS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !vsync |=> vsync); // R6
   AST_HS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) hsync |=> !hsync); // R4
   AST_NO_DOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (hsync || !vsync) |-> !dot_clk); // R4
   AST_DOTS_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      ((hsync || frame_done) && line_open) |-> (line_dots == CW'(PIX_PER_LINE))); // R3
   AST_DOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dot_clk |=> !dot_clk); // R10
   AST_VIDEO_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(dot_clk) |-> $stable(video)); // R10
   AST_DONE_TO_VS: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !vsync); // R8
   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (await_first && mem_rd) |-> (mem_addr == base_addr)); // R7
   AST_READ_OFF_DOT: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> !dot_clk); // R11
   AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) dot_clk |-> (dots_since_rd < 9'd128)); // R11
endmodule

bind rle_raster_player rle_raster_checker #(
   .ADDR_W       (ADDR_W),
   .PIX_PER_LINE (PIX_PER_LINE)
) u_chk (.*);

// File: tb/tb_rle_raster_player.sv
module tb_rle_raster_player;
   localparam int CLK_PERIOD = 10;
   localparam int PX = 16;
   localparam int LN = 4;
   localparam int AW = 8;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [RW-1:0] retrace_len = '0;
   logic          mem_rd;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_data = '0;
   logic          video, dot_clk, hsync, vsync, frame_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   rle_raster_player #(
      .ADDR_W(AW), .RT_W(RW), .PIX_PER_LINE(PX), .LINES_PER_FRAME(LN)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .retrace_len(retrace_len), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_data(mem_data), .video(video), .dot_clk(dot_clk), .hsync(hsync),
      .vsync(vsync), .frame_done(frame_done)
   );

   logic [7:0] mem [0:255];
   always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

   int total = 0;
   int bad = 0;

   bit exp_pix [0:LN-1][0:PX-1];
   int exp_bytes;

   bit cap [0:1][0:LN-1][0:PX-1];
   int cyc, last_vs, nfr, line, xpos, ndone, linebad, setup_bad, idle_bad, addr_bad;
   int period [0:2];
   int nrd [0:1];
   bit await_rd, prev_dot, prev_vid, mon_clr;

   always @(negedge clk) begin
      if (mon_clr) begin
         cyc = 0; last_vs = 0; nfr = 0; line = -1; xpos = 0; ndone = 0;
         linebad = 0; setup_bad = 0; idle_bad = 0; addr_bad = 0;
         period[0] = 0; period[1] = 0; period[2] = 0; nrd[0] = 0; nrd[1] = 0;
         await_rd = 0; prev_dot = 0; prev_vid = 0;
      end else begin
         cyc++;
         if (rst_n) begin
            if (dot_clk && !prev_dot && video != prev_vid) setup_bad++;
            if (nfr == 0 && (mem_rd || dot_clk || hsync || frame_done)) idle_bad++;
            if (!vsync) begin
               if (nfr >= 1 && nfr <= 3) period[nfr-1] = cyc - last_vs;
               last_vs = cyc; nfr++; line = -1; await_rd = 1;
            end
            if (mem_rd) begin
               if (await_rd && mem_addr != base_addr) addr_bad++;
               await_rd = 0;
               if (nfr >= 1 && nfr <= 2) nrd[nfr-1]++;
            end
            if (hsync) begin
               if (line >= 0 && xpos != PX) linebad++;
               line++; xpos = 0;
            end
            if (dot_clk && !prev_dot) begin
               if (nfr >= 1 && nfr <= 2 && line >= 0 && line < LN && xpos < PX)
                  cap[nfr-1][line][xpos] = video;
               xpos++;
            end
            if (frame_done) begin
               ndone++;
               if (line != LN-1 || xpos != PX) linebad++;
            end
         end
         prev_dot = dot_clk; prev_vid = video;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // R2 R3: arithmetic model of the decoder, bytes read in order from base
   task automatic build_expected(input int base);
      int p = base;
      exp_bytes = 0;
      for (int l = 0; l < LN; l++) begin
         int x = 0;
         while (x < PX) begin
            logic [7:0] b = mem[p % 256];
            int len = int'(b[6:0]) + 1;
            p++; exp_bytes++;
            for (int k = 0; k < len && x < PX; k++) begin
               exp_pix[l][x] = b[7];
               x++;
            end
         end
      end
   endtask

   task automatic fill(input int pat, input int base);
      for (int i = 0; i < 256; i++) begin
         logic [7:0] v;
         case (pat)
            0: case (i % 4) 0: v = 8'h00; 1: v = 8'h80; 2: v = 8'h7F; default: v = 8'h7D; endcase
            1: v = 8'hFF;
            2: v = (i % 2 == 0) ? 8'h80 : 8'h00;
            3: v = (i % 2 == 0) ? 8'h82 : 8'h02;
            default: v = 8'($urandom_range(0, 255));
         endcase
         mem[(base + i) % 256] = v;
      end
   endtask

   task automatic run_pattern(input int pat, input int base, input int rt);
      int waited = 0;
      int per, mism;
      rst_n = 1'b0; start = 1'b0;
      base_addr = AW'(base); retrace_len = RW'(rt);
      fill(pat, base);
      build_expected(base);
      mon_clr = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs under reset
      chk(vsync && !hsync && !dot_clk && !video && !mem_rd && !frame_done, "R1", "reset outputs",
          {vsync, hsync, dot_clk, video, mem_rd, frame_done}, 6'b100000);
      mon_clr = 1'b0;
      rst_n = 1'b1;
      repeat (25) @(negedge clk);
      // R9: nothing happens before start
      chk(idle_bad == 0 && nfr == 0, "R9", "activity before start", idle_bad + nfr, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (nfr < 4 && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk(nfr >= 4, "R5", "watchdog, frames seen", nfr, 4);
      for (int f = 0; f < 2; f++) begin
         mism = 0;
         for (int l = 0; l < LN; l++)
            for (int x = 0; x < PX; x++)
               if (cap[f][l][x] != exp_pix[l][x]) mism++;
         chk(mism == 0, "R2", "pixel mismatches (R3 truncation)", mism, 0);
         chk(nrd[f] == exp_bytes, "R11", "reads per frame", nrd[f], exp_bytes);
      end
      per = 1 + LN + 2*exp_bytes + 2*PX*LN + rt + 1;
      for (int k = 0; k < 3; k++)
         chk(period[k] == per, "R5", "frame period", period[k], per);
      chk(linebad == 0, "R4", "lines with wrong dot count", linebad, 0);
      chk(ndone == 3 || ndone == 4, "R8", "frame_done pulses", ndone, 3);
      chk(addr_bad == 0, "R7", "first read not at base", addr_bad, 0);
      chk(setup_bad == 0, "R10", "video changed at dot edge", setup_bad, 0);
   endtask

   initial begin
      mon_clr = 1'b1;
      run_pattern(0, 0, 5);
      run_pattern(1, 17, 0);
      run_pattern(2, 100, 9);
      run_pattern(3, 40, 2);
      run_pattern(4, 230, 17);
      run_pattern(4, 250, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule